// File: doc/BRIEF.md
# LCD Gamma Lookup Stage

This stage sits in an LCD pixel path and applies per-channel gamma correction. It holds one table for each of red, green and blue. Each table has 256 entries of 10 bits. Every 8-bit colour component indexes its own table, and the stored 10-bit value becomes the output component.

Software reaches the tables indirectly through three registers. A control register carries the enable bit and three ready flags. An address register carries the table index, the channel selects, auto-increment and a read request. A data register moves the table words. A typical load runs in this order:

1. Clear enable.
2. Poll address-ready, then write an address word with auto-increment set and index 0.
3. Poll write-ready before each of 256 data words.
4. Repeat steps 2 and 3 for each remaining channel.
5. Set enable.

While enable is clear, the pixel path bypasses the tables. The lookup adds one cycle of delay, and the sideband signals are delayed to match.

Top module: `lcd_gamma_lut`

## Requirements
- R1: After reset, the control register reads 0x0030: address-ready and write-ready are set and every other bit is 0. All pixel outputs and sideband outputs are 0.
- R2: Register select values are 0 for control, 1 for data and 2 for address. Address-ready (control bit 5) and write-ready (control bit 4) read 0 for exactly the one cycle that follows an accepted data or address write. They read 1 at all other times.
- R3: A data or address write issued while the ready flags are 0 is dropped. It changes no table entry, no index and no address field.
- R4: The address word has these fields: bits 7:0 index, bit 8 blue select, bit 9 green select, bit 10 red select, bit 11 auto-increment, bit 12 read request. When auto-increment is set, each data write stores at the current index and then adds one, wrapping from 255 to 0. When auto-increment is clear, the index stays where it is.
- R5: A data write stores its low 10 bits into every table whose select bit is set. Setting several selects loads the same word into several channels.
- R6: While control bit 0 (enable) is 0, each output component is the input component shifted left by two.
- R7: While enable is 1, each output component is the entry of its own channel's table at the input component's value.
- R8: Outputs appear one cycle after the inputs. The valid, hsync, vsync and DE outputs are the inputs delayed by one cycle.
- R9: When read request is set, control bit 3 (read-ready) equals write-ready. A data-port read returns the entry at the current index from the highest-priority selected table, with priority red, then green, then blue. With auto-increment set, a read strobe on the data port advances the index by one.
- R10: Control bits 0, 1, 2, 6 and 7 are stored and read back. Writes to bits 3 to 5 have no effect on them.
- R11: Reading the address port returns the stored read-request, auto-increment and select bits together with the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the index on data reads) |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_sel) |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_hs_i | input | 1 | Input hsync |
| pix_vs_i | input | 1 | Input vsync |
| pix_de_i | input | 1 | Input data enable |
| pix_r_i | input | 8 | Input red |
| pix_g_i | input | 8 | Input green |
| pix_b_i | input | 8 | Input blue |
| pix_vld_o | output | 1 | Delayed valid |
| pix_hs_o | output | 1 | Delayed hsync |
| pix_vs_o | output | 1 | Delayed vsync |
| pix_de_o | output | 1 | Delayed data enable |
| pix_r_o | output | 10 | Corrected red |
| pix_g_o | output | 10 | Corrected green |
| pix_b_o | output | 10 | Corrected blue |

## Verification
The red table is loaded with a descending ramp, and green and blue share an ascending ramp loaded in one pass. The pixel vectors drive different values on all three components at once, so a swapped channel or a wrong table shows up as a mismatch. The vectors cover indices 0, 255, 0x23 and mid-range values, with enable both set and clear, which separates the lookup from the shift bypass. Directed patterns then cover the remaining cases:
- an overwrite without auto-increment;
- an index wrap at 255;
- back-to-back writes where the second is dropped;
- read-back with several selects set, which exposes the priority order.

// File: rtl/lcd_gamma_lut.sv
module lcd_gamma_lut #(
  parameter int CW = 8,
  parameter int GW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pix_vld_i,
  input  logic          pix_hs_i,
  input  logic          pix_vs_i,
  input  logic          pix_de_i,
  input  logic [CW-1:0] pix_r_i,
  input  logic [CW-1:0] pix_g_i,
  input  logic [CW-1:0] pix_b_i,
  output logic          pix_vld_o,
  output logic          pix_hs_o,
  output logic          pix_vs_o,
  output logic          pix_de_o,
  output logic [GW-1:0] pix_r_o,
  output logic [GW-1:0] pix_g_o,
  output logic [GW-1:0] pix_b_o
);
  localparam int DEPTH = 1 << CW;
  localparam int SHIFT = GW - CW;
  localparam int NCH = 3;
  localparam int SEL_LSB = CW;
  localparam int AUTO_BIT = CW + 3;
  localparam int RDRQ_BIT = CW + 4;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;

  logic [7:0]    ctrl_q;
  logic [CW-1:0] idx_q;
  logic [NCH-1:0] chsel_q;
  logic          autoinc_q;
  logic          rdreq_q;
  logic          busy_q;
  logic [GW-1:0] tbl [NCH][DEPTH];

  wire rdy     = !busy_q;
  wire en      = ctrl_q[0];
  wire ctrl_we = reg_wr && reg_sel == SEL_CTRL;
  wire data_we = reg_wr && reg_sel == SEL_DATA && rdy;
  wire addr_we = reg_wr && reg_sel == SEL_ADDR && rdy;
  wire data_re = reg_rd && reg_sel == SEL_DATA && rdreq_q;

  logic [1:0] rd_ch;
  always_comb begin
    if (chsel_q[0])      rd_ch = 2'd0;
    else if (chsel_q[1]) rd_ch = 2'd1;
    else                 rd_ch = 2'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      idx_q     <= '0;
      chsel_q   <= '0;
      autoinc_q <= 1'b0;
      rdreq_q   <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      busy_q <= data_we || addr_we;
      if (ctrl_we) ctrl_q <= reg_wdata[7:0] & 8'hC7;
      if (addr_we) begin
        idx_q     <= reg_wdata[CW-1:0];
        chsel_q   <= {reg_wdata[SEL_LSB], reg_wdata[SEL_LSB+1], reg_wdata[SEL_LSB+2]};
        autoinc_q <= reg_wdata[AUTO_BIT];
        rdreq_q   <= reg_wdata[RDRQ_BIT];
      end else if ((data_we || data_re) && autoinc_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++)
      if (data_we && chsel_q[c]) tbl[c][idx_q] <= reg_wdata[GW-1:0];
  end

  logic [DW-1:0] ctrl_rd, data_rd, addr_rd;
  assign ctrl_rd = DW'({ctrl_q[7:6], rdy, rdy, rdreq_q && rdy, ctrl_q[2:0]});
  assign data_rd = rdreq_q ? DW'(tbl[rd_ch][idx_q]) : '0;
  assign addr_rd = DW'({rdreq_q, autoinc_q, chsel_q[0], chsel_q[1], chsel_q[2], idx_q});

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_rd;
      SEL_DATA: reg_rdata = data_rd;
      SEL_ADDR: reg_rdata = addr_rd;
      default:  reg_rdata = '0;
    endcase
  end

  logic [CW-1:0] px_in  [NCH];
  logic [GW-1:0] px_out [NCH];
  assign px_in[0] = pix_r_i;
  assign px_in[1] = pix_g_i;
  assign px_in[2] = pix_b_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) px_out[c] <= '0;
      else        px_out[c] <= en ? tbl[c][px_in[c]] : {px_in[c], {SHIFT{1'b0}}};
    end
  end

  assign pix_r_o = px_out[0];
  assign pix_g_o = px_out[1];
  assign pix_b_o = px_out[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {pix_vld_o, pix_hs_o, pix_vs_o, pix_de_o} <= '0;
    else        {pix_vld_o, pix_hs_o, pix_vs_o, pix_de_o} <= {pix_vld_i, pix_hs_i, pix_vs_i, pix_de_i};
  end
endmodule

// File: rtl/lcd_gamma_lut_chk.sv
module lcd_gamma_lut_chk #(
  parameter int CW = 8,
  parameter int GW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] reg_rdata,
  input logic          pix_vld_i,
  input logic          pix_hs_i,
  input logic          pix_vld_o,
  input logic          pix_hs_o,
  input logic [CW-1:0] pix_r_i,
  input logic [GW-1:0] pix_r_o,
  input logic          busy_q,
  input logic          autoinc_q,
  input logic          en,
  input logic [CW-1:0] idx_q
);
  wire acc_wr = reg_wr && (reg_sel == 2'd1 || reg_sel == 2'd2) && !busy_q;

  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (reg_sel != 2'd0 || reg_rdata[5:4] == 2'b00)); // R2
  AST_RDY_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && busy_q && !reg_rd) |=> $stable(idx_q)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && reg_sel == 2'd1 && autoinc_q) |=> idx_q == $past(idx_q) + 1'b1); // R4
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && !en) |=> pix_r_o == {$past(pix_r_i), {(GW-CW){1'b0}}}); // R6
  AST_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && pix_hs_i) |=> (pix_vld_o && pix_hs_o)); // R8
endmodule

bind lcd_gamma_lut lcd_gamma_lut_chk #(.CW(CW), .GW(GW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .pix_vld_i(pix_vld_i), .pix_hs_i(pix_hs_i),
  .pix_vld_o(pix_vld_o), .pix_hs_o(pix_hs_o), .pix_r_i(pix_r_i), .pix_r_o(pix_r_o),
  .busy_q(busy_q), .autoinc_q(autoinc_q), .en(en), .idx_q(idx_q)
);

// File: tb/lcd_gamma_lut_tb.sv
module lcd_gamma_lut_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic vi = 0, hi = 0, si = 0, di = 0, vo, ho, so, dout;
  logic [7:0] ri = 0, gi = 0, bi = 0;
  logic [9:0] ro, go, bo;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_gamma_lut dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_vld_i(vi), .pix_hs_i(hi),
    .pix_vs_i(si), .pix_de_i(di), .pix_r_i(ri), .pix_g_i(gi), .pix_b_i(bi),
    .pix_vld_o(vo), .pix_hs_o(ho), .pix_vs_o(so), .pix_de_o(dout),
    .pix_r_o(ro), .pix_g_o(go), .pix_b_o(bo));

  localparam logic [15:0] AUTO = 16'h0800, RDRQ = 16'h1000;
  localparam logic [15:0] SR = 16'h0400, SG = 16'h0200, SB = 16'h0100;

  // stimulus: {vld, hs, vs, de, r, g, b}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {4'b1001, 8'h00, 8'h00, 8'h00}, {4'b1001, 8'hFF, 8'hFF, 8'hFF},
    {4'b1101, 8'h23, 8'h10, 8'h80}, {4'b1011, 8'h7F, 8'hC3, 8'h01},
    {4'b0000, 8'h55, 8'hAA, 8'h3C}, {4'b1001, 8'h01, 8'hFE, 8'h64},
    {4'b1111, 8'h90, 8'h0F, 8'hE7}, {4'b1001, 8'h40, 8'h41, 8'h42}};

  function automatic logic [9:0] fr(input int i); return 10'(1023 - 4 * i); endfunction
  function automatic logic [9:0] fg(input int i); return 10'((5 * i + 7) & 1023); endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wait_rdy();
    reg_sel = 0; #1;
    while (reg_rdata[4] !== 1'b1) begin @(negedge clk); #1; end
  endtask

  task automatic load(input logic [15:0] mask, input bit red);
    wait_rdy(); wr_reg(2, AUTO | mask);
    for (int i = 0; i < 256; i++) begin
      wait_rdy(); wr_reg(1, {6'd0, red ? fr(i) : fg(i)});
    end
  endtask

  task automatic rd_entry(input logic [15:0] mask, input logic [7:0] idx, output logic [15:0] v);
    wait_rdy(); wr_reg(2, RDRQ | mask | idx);
    wait_rdy(); reg_sel = 1; #1; v = reg_rdata;
  endtask

  logic [15:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 ctrl reset", reg_rdata, 16'h0030);
    chk("R1 outputs reset", {ro, vo, ho, so, dout}, 0);

    wr_reg(0, 16'h00FE); #1;
    chk("R10 ctrl rw bits", reg_rdata, 16'h00F6);
    wr_reg(0, 16'h0000);

    @(negedge clk); ri = 8'h81; gi = 8'h02; bi = 8'hFF; vi = 1;
    @(negedge clk); #1;
    chk("R6 bypass", {ro, go}, {10'h204, 10'h008});
    chk("R6 bypass b", bo, 10'h3FC);
    vi = 0;

    load(SR, 1);
    load(SG | SB, 0);
    wait_rdy(); wr_reg(2, AUTO | SB | 16'h23);
    reg_sel = 0; #1;
    chk("R2 ready low after write", reg_rdata[5:3], 3'b000);
    @(negedge clk); #1;
    chk("R2 ready restored", reg_rdata[5:4], 2'b11);
    reg_sel = 2; #1;
    chk("R11 address readback", reg_rdata, 16'h0923);
    wr_reg(0, 16'h0001);

    for (int n = 0; n < NV; n++) begin
      {vi, hi, si, di, ri, gi, bi} = VEC[n];
      #1;
      if (n > 0) chk("R8 output held until edge", {6'd0, vo, ho, so, dout},
                     {12'd0, VEC[n-1][27:24]});
      @(negedge clk); #1;
      chk("R8 sideband delay", {12'd0, vo, ho, so, dout}, {12'd0, VEC[n][27:24]});
      chk("R7 red lookup", ro, fr(VEC[n][23:16]));
      chk("R7 green lookup", go, fg(VEC[n][15:8]));
      chk("R5 blue shares green data", bo, fg(VEC[n][7:0]));
    end
    vi = 0; hi = 0; si = 0; di = 0;

    rd_entry(SR | SG, 8'h05, v);
    chk("R9 red priority", v, fr(5));
    reg_sel = 0; #1;
    chk("R9 read-ready", reg_rdata[3], 1'b1);
    rd_entry(AUTO | SG | SB, 8'h07, v);
    chk("R9 green priority", v, fg(7));
    @(negedge clk); reg_sel = 1; reg_rd = 1;
    @(negedge clk); reg_rd = 0; #1;
    chk("R9 read auto-increment", reg_rdata, fg(8));

    wait_rdy(); wr_reg(2, SR | 16'h10);
    wait_rdy(); wr_reg(1, 16'd100);
    wait_rdy(); wr_reg(1, 16'd200);
    reg_sel = 2; #1;
    chk("R4 index held without auto", reg_rdata, 16'h0410);
    rd_entry(SR, 8'h10, v); chk("R4 overwrite", v, 16'd200);
    rd_entry(SR, 8'h11, v); chk("R4 neighbour untouched", v, fr(17));

    wait_rdy(); wr_reg(2, AUTO | SR | 16'hFF);
    wait_rdy(); wr_reg(1, 16'd11);
    wait_rdy(); wr_reg(1, 16'd22);
    reg_sel = 2; #1;
    chk("R4 index wrap", reg_rdata, 16'h0C01);
    rd_entry(SR, 8'hFF, v); chk("R4 entry 255", v, 16'd11);
    rd_entry(SR, 8'h00, v); chk("R4 entry 0 after wrap", v, 16'd22);

    wait_rdy(); wr_reg(2, AUTO | SG | 16'h40);
    wait_rdy();
    @(negedge clk); reg_sel = 1; reg_wdata = 16'd500; reg_wr = 1;
    @(negedge clk); reg_wdata = 16'd600;
    @(negedge clk); reg_wr = 0;
    reg_sel = 2; #1;
    chk("R3 busy write dropped idx", reg_rdata, 16'h0A41);
    rd_entry(SG, 8'h40, v); chk("R3 first write kept", v, 16'd500);
    rd_entry(SG, 8'h41, v); chk("R3 busy data not stored", v, fg(65));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule